// File: doc/BRIEF.md
# Sprite Line Selector and Pixel Compositor

This block chooses, once per scan line, which of the 64 sprite descriptors are drawn on the next line. It then lays those sprites over the background stream pixel by pixel. The selection pass starts when the dot counter reaches 257. It walks the descriptor table, which it reads one 32-bit entry per cycle. It keeps the first eight entries whose vertical span covers the next line, in table order, and raises a sticky overflow flag when a ninth entry also covers that line. When the pass ends, the block fetches the low and high pattern bytes for each kept sprite from pattern memory. Vertical flip, horizontal flip and tall-sprite bank selection are resolved at this point, and the result is held as eight ready-to-shift rows. All of this is finished before the next line's first visible dot.

During dots 1 to 256 of visible lines, the compositor takes the background index for pixel `dot-1`. It looks up every held sprite that covers that column, keeps the lowest-slot opaque one, and registers the final 5-bit palette index. A background-priority bit in the sprite attributes can hide a sprite behind opaque background. An opaque slot-0 pixel over opaque background sets a sticky hit flag. A clear pulse from the frame timing logic resets both flags.

Top module: `sprite_compositor`

## Requirements
- R1: A descriptor covers target line T when Y ≤ T < Y + H. H is 16 when `tall_mode` is 1 and 8 otherwise.
- R2: A descriptor word holds Y in bits 7:0, the tile in 15:8, the attribute in 23:16 and X in 31:24. Up to eight covering descriptors are kept in slots 0..7, in ascending table index.
- R3: A ninth covering descriptor sets `spr_overflow` and ends the pass. With exactly eight covering descriptors the flag stays clear.
- R4: The pass starts at dot 257 of lines 0–239 and targets line+1. Dot 257 of any other line empties the list. Sprites are drawn only on lines 0–239 at dots 1–256, for column x = dot−1.
- R5: Attribute bit 7 set flips the sprite vertically, so the fetched row is H−1−(T−Y).
- R6: Attribute bit 6 set flips the sprite horizontally, so column x uses pattern bit x−X instead of bit 7−(x−X).
- R7: Pattern addresses have the form {bank, tile, plane, row[2:0]}, where plane 1 is the high byte. For 8-pixel sprites the bank is `small_bank`. For 16-pixel sprites the bank is tile bit 0, the tile bit 0 is replaced by row bit 3, and rows 8–15 therefore read the second tile of the pair.
- R8: A sprite pixel value of 0 is transparent. A shown sprite yields `pix_out` = 16 + 4×attr[1:0] + pixel. Otherwise `pix_out` equals `bg_idx` when bg_idx[1:0] ≠ 0 and 0 when the background is transparent. The value for a dot appears after the clock edge at which that dot is presented.
- R9: Attribute bit 5 set hides the sprite wherever the background is opaque. Where the background is transparent, the sprite is still shown.
- R10: Where several kept sprites are opaque at a column, the one in the lowest slot decides the pixel.
- R11: `spr_zero_hit` is set when slot 0 gives an opaque pixel at a column whose background is opaque.
- R12: With `spr_enable` low, `pix_out` follows the background rule of R8 and `spr_zero_hit` is not set.
- R13: Both flags reset to 0, stay set once set, and clear one cycle after a `flag_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tall_mode | input | 1 | 1 selects 8×16 sprites |
| small_bank | input | 1 | Pattern bank for 8×8 sprites |
| spr_enable | input | 1 | Sprite drawing enable |
| line | input | 9 | Current scan line, 0–261 |
| dot | input | 9 | Current dot, 0–340 |
| bg_idx | input | 4 | Background palette index, bits 1:0 = pattern value |
| flag_clr | input | 1 | Clears the overflow and hit flags |
| oam_idx | output | 6 | Descriptor table read index |
| oam_word | input | 32 | Descriptor read data, combinational |
| pat_addr | output | 13 | Pattern memory read address |
| pat_data | input | 8 | Pattern read data, combinational |
| pix_out | output | 5 | Final palette index |
| spr_overflow | output | 1 | Sticky line overflow flag |
| spr_zero_hit | output | 1 | Sticky slot-0 hit flag |

## Verification
The bench sweeps every column of a line after each selection pass. The lines are chosen one below, inside and one past each sprite's span, so every match boundary is crossed in both sprite heights. The first table mixes flipped, overlapping, behind-priority and right-edge sprites; it separates slot order from X order and separates each flip axis. A tall-sprite table probes rows on both sides of the tile-pair split. A ten-sprite line and an eight-sprite line separate overflow from a full list. Further runs with drawing disabled, on the pre-render line and on an off-screen line show that nothing leaks outside the drawing window.

// File: rtl/spr_pkg.sv
// Shared descriptor layout and attribute bit positions for the sprite
// compositor. Assumes one descriptor is read as a single 32-bit word.
package spr_pkg;
    typedef struct packed {
        logic [7:0] xpos;
        logic [7:0] attr;
        logic [7:0] tile;
        logic [7:0] ypos;
    } spr_ent_t;

    localparam int ATTR_VFLIP  = 7;
    localparam int ATTR_HFLIP  = 6;
    localparam int ATTR_BEHIND = 5;
endpackage

// File: rtl/spr_eval.sv
// Line selection pass. On start it walks the descriptor table one entry
// per cycle and keeps the first N_SLOT entries that cover line_in+1.
// Assumes oam_word answers oam_idx within the same cycle. On lines at or
// past VIS_LINES, start only empties the list.
module spr_eval
    import spr_pkg::*;
#(
    parameter int N_ENT     = 64,
    parameter int N_SLOT    = 8,
    parameter int VIS_LINES = 240,
    parameter int IDX_W     = $clog2(N_ENT),
    parameter int CNT_W     = $clog2(N_SLOT + 1),
    parameter int SLOT_W    = $clog2(N_SLOT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [8:0]              line_in,
    input  logic                    tall,
    input  logic                    flag_clr,
    input  spr_ent_t                oam_word,
    output logic [IDX_W-1:0]        oam_idx,
    output spr_ent_t [N_SLOT-1:0]   slots,
    output logic [CNT_W-1:0]        count,
    output logic [8:0]              target,
    output logic                    ovf,
    output logic                    done
);
    logic             busy;
    logic [IDX_W-1:0] idx;
    logic [9:0]       y_lo;
    logic [9:0]       y_hi;
    logic             covers;
    logic             full;
    logic             last;

    assign oam_idx = idx;

    // Window test of the entry currently on the read port.
    always_comb begin
        y_lo   = {2'b00, oam_word.ypos};
        y_hi   = y_lo + (tall ? 10'd16 : 10'd8);
        covers = busy && ({1'b0, target} >= y_lo) && ({1'b0, target} < y_hi);
        full   = (count == CNT_W'(N_SLOT));
        last   = (idx == IDX_W'(N_ENT - 1));
    end

    // Scan sequencer and slot fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            count  <= '0;
            target <= '0;
            done   <= 1'b0;
            slots  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy   <= (line_in < 9'(VIS_LINES));
                idx    <= '0;
                count  <= '0;
                target <= line_in + 9'd1;
            end else if (busy) begin
                idx <= idx + 1'b1;
                if (covers && !full) begin
                    slots[count[SLOT_W-1:0]] <= oam_word;
                    count <= count + 1'b1;
                end
                if ((covers && full) || last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Sticky overflow flag, the clear pulse taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (flag_clr)
            ovf <= 1'b0;
        else if (covers && full)
            ovf <= 1'b1;
    end

    a_r2_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(N_SLOT));
    a_r3_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> full);
    a_r3_scan_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (covers && full && !flag_clr) |=> (!busy && ovf));
    a_r4_offscreen_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (start && line_in >= 9'(VIS_LINES)) |=> (!busy && count == '0));
endmodule

// File: rtl/spr_fetch.sv
// Row fetch for the kept slots. After the selection pass it reads the
// low and high pattern bytes of every slot, two cycles per slot. It
// resolves vertical flip and tall-pair banking in the address and
// horizontal flip by reversing the byte. Assumes pat_data answers
// pat_addr within the same cycle.
module spr_fetch
    import spr_pkg::*;
#(
    parameter int N_SLOT = 8,
    parameter int STEP_W = $clog2(2 * N_SLOT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        tall,
    input  logic                        bank_sel,
    input  logic [3:0]                  tgt_lo,
    input  spr_ent_t [N_SLOT-1:0]       slots,
    output logic [12:0]                 pat_addr,
    input  logic [7:0]                  pat_data,
    output logic [N_SLOT-1:0][7:0]      row_lo,
    output logic [N_SLOT-1:0][7:0]      row_hi
);
    logic              busy;
    logic [STEP_W-1:0] step;
    spr_ent_t          cur;
    logic              plane;
    logic [3:0]        offs;
    logic [3:0]        row;
    logic [7:0]        fetched;

    // Address of the current slot and plane, and the flipped data byte.
    always_comb begin
        cur   = slots[step[STEP_W-1:1]];
        plane = step[0];
        offs  = tgt_lo - cur.ypos[3:0];
        row   = cur.attr[ATTR_VFLIP] ? ((tall ? 4'd15 : 4'd7) - offs) : offs;
        if (tall)
            pat_addr = {cur.tile[0], cur.tile[7:1], row[3], plane, row[2:0]};
        else
            pat_addr = {bank_sel, cur.tile, plane, row[2:0]};
        for (int b = 0; b < 8; b++)
            fetched[b] = cur.attr[ATTR_HFLIP] ? pat_data[7 - b] : pat_data[b];
    end

    // Step through all slot and plane pairs, storing each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            step   <= '0;
            row_lo <= '0;
            row_hi <= '0;
        end else if (start) begin
            busy <= 1'b1;
            step <= '0;
        end else if (busy) begin
            if (plane)
                row_hi[step[STEP_W-1:1]] <= fetched;
            else
                row_lo[step[STEP_W-1:1]] <= fetched;
            step <= step + 1'b1;
            if (step == STEP_W'(2 * N_SLOT - 1))
                busy <= 1'b0;
        end
    end

    a_r7_fetch_follows_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r7_fetch_length: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step == STEP_W'(2 * N_SLOT - 1) && !start) |=> !busy);
endmodule

// File: rtl/spr_mix.sv
// Per-pixel compositor. For column x it extracts each kept slot's 2-bit
// pixel, picks the lowest opaque slot, applies background priority and
// registers the palette index. Also keeps the sticky slot-0 hit flag.
// Assumes the rows were fetched with horizontal flip already applied.
module spr_mix
    import spr_pkg::*;
#(
    parameter int N_SLOT = 8,
    parameter int CNT_W  = $clog2(N_SLOT + 1),
    parameter int SLOT_W = $clog2(N_SLOT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        active,
    input  logic [7:0]                  xcol,
    input  logic [3:0]                  bg_idx,
    input  logic                        flag_clr,
    input  spr_ent_t [N_SLOT-1:0]       slots,
    input  logic [N_SLOT-1:0][7:0]      row_lo,
    input  logic [N_SLOT-1:0][7:0]      row_hi,
    input  logic [CNT_W-1:0]            count,
    output logic [4:0]                  pix_out,
    output logic                        hit
);
    logic [1:0]        px [N_SLOT];
    logic [N_SLOT-1:0] opq;
    logic              win;
    logic [SLOT_W-1:0] wsel;
    logic              bg_opq;
    logic [4:0]        bg_val;
    logic [4:0]        nxt;

    // One column decoder per slot.
    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        logic [8:0] dx;
        logic [2:0] bsel;
        logic       in_rng;
        always_comb begin
            dx     = {1'b0, xcol} - {1'b0, slots[i].xpos};
            in_rng = (xcol >= slots[i].xpos) && (dx < 9'd8);
            bsel   = 3'd7 - dx[2:0];
            px[i]  = {row_hi[i][bsel], row_lo[i][bsel]};
            opq[i] = active && (CNT_W'(i) < count) && in_rng && (px[i] != 2'b00);
        end
    end

    // Lowest opaque slot wins; then background priority decides.
    always_comb begin
        wsel = '0;
        for (int i = N_SLOT - 1; i >= 0; i--)
            if (opq[i]) wsel = SLOT_W'(i);
        win    = |opq;
        bg_opq = (bg_idx[1:0] != 2'b00);
        bg_val = bg_opq ? {1'b0, bg_idx} : 5'd0;
        if (win && (!slots[wsel].attr[ATTR_BEHIND] || !bg_opq))
            nxt = {1'b1, slots[wsel].attr[1:0], px[wsel]};
        else
            nxt = bg_val;
    end

    // Output pixel register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pix_out <= '0;
        else
            pix_out <= nxt;
    end

    // Sticky slot-0 hit flag, the clear pulse taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hit <= 1'b0;
        else if (flag_clr)
            hit <= 1'b0;
        else if (opq[0] && bg_opq)
            hit <= 1'b1;
    end

    a_r8_sprite_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out[4] |-> $past(win));
    a_r11_hit_over_bg: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(bg_opq));
    a_r12_hit_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(active));
    a_r13_hit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !hit);
endmodule

// File: rtl/sprite_compositor.sv
// Top of the sprite path. It derives the pass start and the drawing
// window from the dot and line counters, and wires the selection pass,
// the row fetch and the pixel compositor together. Assumes both memory
// read ports return data in the cycle their address is presented.
module sprite_compositor
    import spr_pkg::*;
#(
    parameter int N_ENT     = 64,
    parameter int N_SLOT    = 8,
    parameter int VIS_LINES = 240,
    parameter int EVAL_DOT  = 257,
    parameter int LAST_DOT  = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tall_mode,
    input  logic        small_bank,
    input  logic        spr_enable,
    input  logic [8:0]  line,
    input  logic [8:0]  dot,
    input  logic [3:0]  bg_idx,
    input  logic        flag_clr,
    output logic [5:0]  oam_idx,
    input  logic [31:0] oam_word,
    output logic [12:0] pat_addr,
    input  logic [7:0]  pat_data,
    output logic [4:0]  pix_out,
    output logic        spr_overflow,
    output logic        spr_zero_hit
);
    localparam int IDX_W  = $clog2(N_ENT);
    localparam int CNT_W  = $clog2(N_SLOT + 1);
    localparam int SLOT_W = $clog2(N_SLOT);

    spr_ent_t [N_SLOT-1:0]  slots;
    logic [N_SLOT-1:0][7:0] row_lo;
    logic [N_SLOT-1:0][7:0] row_hi;
    logic [CNT_W-1:0]       count;
    logic [8:0]             target;
    logic                   pass_done;
    logic                   start;
    logic                   active;
    logic [7:0]             xcol;
    logic [IDX_W-1:0]       idx;

    // Pass trigger, drawing window and column number.
    always_comb begin
        start  = (dot == 9'(EVAL_DOT));
        active = spr_enable && (line < 9'(VIS_LINES)) &&
                 (dot >= 9'd1) && (dot <= 9'(LAST_DOT));
        xcol   = dot[7:0] - 8'd1;
    end

    assign oam_idx = 6'(idx);

    spr_eval #(
        .N_ENT(N_ENT), .N_SLOT(N_SLOT), .VIS_LINES(VIS_LINES),
        .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) u_eval (
        .clk(clk), .rst_n(rst_n), .start(start), .line_in(line),
        .tall(tall_mode), .flag_clr(flag_clr), .oam_word(oam_word),
        .oam_idx(idx), .slots(slots), .count(count), .target(target),
        .ovf(spr_overflow), .done(pass_done)
    );

    spr_fetch #(.N_SLOT(N_SLOT)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(pass_done), .tall(tall_mode),
        .bank_sel(small_bank), .tgt_lo(target[3:0]), .slots(slots),
        .pat_addr(pat_addr), .pat_data(pat_data),
        .row_lo(row_lo), .row_hi(row_hi)
    );

    spr_mix #(.N_SLOT(N_SLOT), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .active(active), .xcol(xcol),
        .bg_idx(bg_idx), .flag_clr(flag_clr), .slots(slots),
        .row_lo(row_lo), .row_hi(row_hi), .count(count),
        .pix_out(pix_out), .hit(spr_zero_hit)
    );

    a_r13_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !spr_overflow);
    a_r4_no_sprite_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pix_out[4]);
endmodule

// File: tb/tb_sprite_compositor.sv
// Sweep bench: loads descriptor tables, runs a selection pass on chosen
// lines and compares every column of the following line with a model
// built from the requirements.
module tb_sprite_compositor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tall_mode = 1'b0;
    logic        small_bank = 1'b0;
    logic        spr_enable = 1'b1;
    logic [8:0]  line = '0;
    logic [8:0]  dot = '0;
    logic [3:0]  bg_idx = '0;
    logic        flag_clr = 1'b0;
    logic [5:0]  oam_idx;
    logic [31:0] oam_word;
    logic [12:0] pat_addr;
    logic [7:0]  pat_data;
    logic [4:0]  pix_out;
    logic        spr_overflow;
    logic        spr_zero_hit;

    int checks = 0;
    int failures = 0;
    logic [31:0] oam_mem [64];
    int  sel [8];
    int  nsel;
    bit  exp_ovf;
    bit  exp_hit;

    always #5 clk = ~clk;

    function automatic logic [7:0] pat_f(input logic [12:0] a);
        logic [15:0] t;
        t = (16'(a) * 16'd29) ^ 16'(a >> 5);
        return t[7:0] & 8'hDB;
    endfunction

    function automatic logic [3:0] bg_f(input int x, input int ln);
        int t;
        t = x * 5 + ln * 3;
        return 4'((t >> 1) & 15);
    endfunction

    assign oam_word = oam_mem[oam_idx];
    assign pat_data = pat_f(pat_addr);

    sprite_compositor dut (
        .clk(clk), .rst_n(rst_n), .tall_mode(tall_mode), .small_bank(small_bank),
        .spr_enable(spr_enable), .line(line), .dot(dot), .bg_idx(bg_idx),
        .flag_clr(flag_clr), .oam_idx(oam_idx), .oam_word(oam_word),
        .pat_addr(pat_addr), .pat_data(pat_data), .pix_out(pix_out),
        .spr_overflow(spr_overflow), .spr_zero_hit(spr_zero_hit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_oam();
        for (int i = 0; i < 64; i++) oam_mem[i] = {8'd0, 8'd0, 8'd0, 8'd250};
    endtask

    task automatic set_ent(input int i, input int y, input int tile, input int attr, input int x);
        oam_mem[i] = {8'(x), 8'(attr), 8'(tile), 8'(y)};
    endtask

    // Model of the selection pass (R1, R2, R3, R4).
    task automatic model_pass(input int ln);
        int h;
        int y;
        nsel = 0;
        exp_ovf = 0;
        h = tall_mode ? 16 : 8;
        if (ln < 240) begin
            for (int i = 0; i < 64; i++) begin
                y = int'(oam_mem[i][7:0]);
                if (ln + 1 >= y && ln + 1 < y + h) begin
                    if (nsel < 8) begin
                        sel[nsel] = i;
                        nsel++;
                    end else begin
                        exp_ovf = 1;
                        break;
                    end
                end
            end
        end
    endtask

    // Model of one column (R5 to R12).
    function automatic int model_pix(input int x, input int ln, input logic [3:0] bg);
        int h, sx, y, offs, addr, sh, p, tile;
        logic [7:0] attr, lo, hi;
        bit bgop;
        bgop = (bg[1:0] != 2'b00);
        h = tall_mode ? 16 : 8;
        if (spr_enable && ln < 240) begin
            for (int j = 0; j < nsel; j++) begin
                sx = int'(oam_mem[sel[j]][31:24]);
                y = int'(oam_mem[sel[j]][7:0]);
                tile = int'(oam_mem[sel[j]][15:8]);
                attr = oam_mem[sel[j]][23:16];
                if (x >= sx && x < sx + 8) begin
                    offs = ln - y;
                    if (attr[7]) offs = h - 1 - offs;
                    if (tall_mode)
                        addr = (tile % 2) * 4096 + (tile / 2) * 32 + (offs / 8) * 16 + (offs % 8);
                    else
                        addr = int'(small_bank) * 4096 + tile * 16 + offs;
                    lo = pat_f(13'(addr));
                    hi = pat_f(13'(addr + 8));
                    sh = attr[6] ? (x - sx) : (7 - (x - sx));
                    p = int'(hi[sh]) * 2 + int'(lo[sh]);
                    if (p != 0) begin
                        if (j == 0 && bgop) exp_hit = 1;
                        if (!attr[5] || !bgop) return 16 + int'(attr[1:0]) * 4 + p;
                        return int'(bg);
                    end
                end
            end
        end
        return bgop ? int'(bg) : 0;
    endfunction

    // Pass on line ln, then sweep every column of the next line.
    task automatic run_line(input int ln, input string tag);
        int nl;
        int e;
        @(negedge clk);
        flag_clr = 1'b1; dot = 9'd0; line = 9'(ln);
        @(negedge clk);
        flag_clr = 1'b0;
        model_pass(ln);
        dot = 9'd257;
        @(negedge clk);
        for (int d = 258; d <= 340; d++) begin
            dot = 9'(d);
            @(negedge clk);
        end
        chk(spr_overflow == exp_ovf, {tag, " overflow R3"}, int'(spr_overflow), int'(exp_ovf));
        nl = (ln == 261) ? 0 : ln + 1;
        line = 9'(nl); dot = 9'd0;
        @(negedge clk);
        exp_hit = 0;
        for (int d = 1; d <= 256; d++) begin
            dot = 9'(d);
            bg_idx = bg_f(d - 1, nl);
            @(negedge clk);
            e = model_pix(d - 1, nl, bg_idx);
            chk(int'(pix_out) == e, $sformatf("%s pixel x=%0d line=%0d", tag, d - 1, nl),
                int'(pix_out), e);
        end
        chk(spr_zero_hit == exp_hit, {tag, " hit R11"}, int'(spr_zero_hit), int'(exp_hit));
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic load_table_a();
        clear_oam();
        set_ent(0, 20, 8'h05, 8'h00, 10);
        set_ent(1, 20, 8'h07, 8'h41, 14);
        set_ent(2, 18, 8'h09, 8'h82, 100);
        set_ent(3, 22, 8'h03, 8'h23, 12);
        set_ent(4, 19, 8'h80, 8'hC0, 252);
        set_ent(5, 24, 8'h0C, 8'h61, 200);
    endtask

    initial begin
        #1_500_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_oam();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_out == 5'd0, "R8 reset pixel", int'(pix_out), 0);
        chk(spr_overflow == 1'b0, "R13 reset overflow", int'(spr_overflow), 0);
        chk(spr_zero_hit == 1'b0, "R13 reset hit", int'(spr_zero_hit), 0);

        // Small sprites: windows, order, flips, priority, hit.
        load_table_a();
        for (int ln = 17; ln <= 27; ln++)
            run_line(ln, "R1 R2 R4 R5 R6 R8 R9 R10 R11");
        small_bank = 1'b1;
        run_line(20, "R7 small bank");
        small_bank = 1'b0;

        // Sticky hit and its clear.
        run_line(19, "R11 hit line");
        chk(spr_zero_hit == exp_hit, "R13 hit held", int'(spr_zero_hit), int'(exp_hit));
        pulse_clear();
        chk(spr_zero_hit == 1'b0, "R13 hit cleared", int'(spr_zero_hit), 0);

        // Drawing disabled.
        spr_enable = 1'b0;
        run_line(19, "R12 disabled");
        spr_enable = 1'b1;

        // Tall sprites on both sides of the pair split.
        tall_mode = 1'b1;
        clear_oam();
        set_ent(0, 40, 8'h11, 8'h00, 30);
        set_ent(1, 40, 8'h22, 8'h80, 60);
        set_ent(2, 45, 8'h35, 8'hC1, 35);
        set_ent(3, 33, 8'h04, 8'h22, 0);
        foreach (sel[k]) sel[k] = 0;
        for (int k = 0; k < 9; k++)
            run_line(38 + k * 2, "R1 R5 R7 tall");
        run_line(55, "R7 tall last row");
        run_line(56, "R1 tall past end");
        tall_mode = 1'b0;

        // Overflow with ten, none with exactly eight.
        clear_oam();
        for (int i = 0; i < 10; i++) set_ent(i, 100, 8'h10 + i, i % 4, i * 24);
        run_line(99, "R3 ten covering");
        chk(spr_overflow == 1'b1, "R13 overflow held", int'(spr_overflow), 1);
        pulse_clear();
        chk(spr_overflow == 1'b0, "R13 overflow cleared", int'(spr_overflow), 0);
        set_ent(8, 200, 8'h18, 0, 192);
        set_ent(9, 200, 8'h19, 0, 216);
        run_line(99, "R3 exactly eight");

        // Lines outside the drawing window.
        clear_oam();
        set_ent(0, 0, 8'h05, 8'h00, 10);
        set_ent(1, 246, 8'h06, 8'h00, 40);
        run_line(261, "R4 pre-render to line 0");
        run_line(245, "R4 off-screen line");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule